// File: doc/BRIEF.md
# Packed SIMD Halving Add/Subtract Unit

This unit takes two packed vector operands, cuts them into equal lanes of 8, 16 or 32 bits, and forms a sum or a difference in each lane. It then halves that value with a one-bit right shift and packs the lane results into one result vector. Control inputs select the operation, whether elements are signed or unsigned, the lane size, and whether the vector is 64 or 128 bits wide.

Each lane computes its sum or difference one bit wider than the lane itself. The shift brings that extra bit back into the result, so a halved result always fits its lane. The halving truncates toward minus infinity and never rounds.

The result and an illegal-encoding flag are registered once. They appear one clock after the inputs are sampled, with no handshake. The unit is meant to sit in an execution pipeline behind an instruction decoder that drives the control inputs directly.

Top module: `halving_simd_unit`

## Requirements
- R1: With `sub_sel`=0, every lane of the result equals floor((A+B)/2). The sum is formed at full precision, one bit wider than the lane, so it never wraps.
- R2: With `sub_sel`=1, every lane of the result equals floor((A-B)/2), where A is the lane element of `opa_i` and B is the lane element of `opb_i`.
- R3: With `uns_sel`=0, elements are two's-complement signed. With `uns_sel`=1, elements are unsigned. In both cases the halved result fits the lane: for example, signed 8-bit 0x80+0x80 gives 0x80, and unsigned 8-bit 0xFF+0xFF gives 0xFF.
- R4: `lane_sz` codes 0, 1 and 2 select 8-, 16- and 32-bit lanes, with lane k at bits [k*W +: W]. No carry or borrow crosses a lane boundary.
- R5: With `wide_sel`=0 the vector is 64 bits wide. Result bits [127:64] are zero, and operand bits [127:64] have no effect on the result. With `wide_sel`=1 the vector is 128 bits wide.
- R6: `lane_sz`=3 is reserved. It sets `illegal_o`=1 and forces the whole result to zero. Any other code gives `illegal_o`=0.
- R7: Result and flag are registered. They reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, both are zero.
- R8: For an unsigned subtract where B exceeds A, the lane result is the low lane-width bits of the floor-halved negative difference. For example, 8-bit 0x00-0x01 gives 0xFF, and 16-bit 0x0000-0xFFFF gives 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opa_i | input | 128 | First operand vector |
| opb_i | input | 128 | Second operand vector |
| sub_sel | input | 1 | 0 = add, 1 = subtract (first minus second) |
| uns_sel | input | 1 | 0 = signed elements, 1 = unsigned elements |
| lane_sz | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit lanes, 3 = reserved |
| wide_sel | input | 1 | 0 = 64-bit vector, 1 = 128-bit vector |
| res_o | output | 128 | Registered packed halved result |
| illegal_o | output | 1 | Registered reserved-size flag |

## Verification
The bench builds the unit with its default 128-bit vector width. This brings every lane size into reach, in both vector lengths, with 16, 8 or 4 lanes active at once, so carries get a chance to cross every boundary between lanes. The vector spans both halves, so the masking of the narrow mode can be observed on real upper-half lanes that are fed with random operands. A model in the bench works on wide integers and does the floor halving by division. It compares every lane for boundary values (minimum, maximum, zero, all ones) and for random operands in all twelve operation, type and size combinations.

// File: rtl/hsimd_pkg.sv
package hsimd_pkg;

  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_B16 = 2'd1,
    LANE_B32 = 2'd2,
    LANE_RSV = 2'd3
  } lane_size_e;

  localparam int NUM_SIZES = 3;
  localparam int MIN_LANE  = 8;

endpackage

// File: rtl/hsimd_lane.sv
module hsimd_lane #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  input  logic          sub_i,
  input  logic          uns_i,
  output logic [LW-1:0] y_o
);

  // Extend by one bit, combine, keep the upper LW bits of the wide value.
  function automatic logic [LW-1:0] halve(
    input logic [LW-1:0] a,
    input logic [LW-1:0] b,
    input logic          sub,
    input logic          uns
  );
    logic [LW:0] ea;
    logic [LW:0] eb;
    logic [LW:0] wide;
    ea   = {(uns ? 1'b0 : a[LW-1]), a};
    eb   = {(uns ? 1'b0 : b[LW-1]), b};
    wide = sub ? (ea - eb) : (ea + eb);
    return wide[LW:1];
  endfunction

  assign y_o = halve(a_i, b_i, sub_i, uns_i);

  // Equal operands: halved sum returns the operand, halved difference is zero.
  always_comb begin
    if (!sub_i && (a_i == b_i)) begin
      p_equal_add_r1: assert (y_o == a_i);
    end
    if (sub_i && (a_i == b_i)) begin
      p_equal_sub_r2: assert (y_o == '0);
    end
  end

endmodule

// File: rtl/hsimd_lane_array.sv
module hsimd_lane_array #(
  parameter int VEC_W = 128,
  parameter int LW    = 8
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             sub_i,
  input  logic             uns_i,
  output logic [VEC_W-1:0] y_o
);

  localparam int NLANES = VEC_W / LW;

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    hsimd_lane #(.LW(LW)) u_lane (
      .a_i   (a_i[k*LW +: LW]),
      .b_i   (b_i[k*LW +: LW]),
      .sub_i (sub_i),
      .uns_i (uns_i),
      .y_o   (y_o[k*LW +: LW])
    );
  end

endmodule

// File: rtl/halving_simd_unit.sv
module halving_simd_unit
  import hsimd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] opa_i,
  input  logic [VEC_W-1:0] opb_i,
  input  logic             sub_sel,
  input  logic             uns_sel,
  input  logic [1:0]       lane_sz,
  input  logic             wide_sel,
  output logic [VEC_W-1:0] res_o,
  output logic             illegal_o
);

  localparam int HALF = VEC_W / 2;

  logic [VEC_W-1:0] sz_res [NUM_SIZES];
  logic [VEC_W-1:0] picked;
  logic [VEC_W-1:0] nxt_res;
  logic             rsv_code;

  for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_size
    localparam int LW = MIN_LANE << gi;
    hsimd_lane_array #(.VEC_W(VEC_W), .LW(LW)) u_arr (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .sub_i (sub_sel),
      .uns_i (uns_sel),
      .y_o   (sz_res[gi])
    );
  end

  assign rsv_code = (lane_size_e'(lane_sz) == LANE_RSV);

  always_comb begin
    case (lane_size_e'(lane_sz))
      LANE_B8:  picked = sz_res[0];
      LANE_B16: picked = sz_res[1];
      LANE_B32: picked = sz_res[2];
      default:  picked = '0;
    endcase
  end

  always_comb begin
    nxt_res = picked;
    if (!wide_sel) nxt_res[VEC_W-1:HALF] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o     <= '0;
      illegal_o <= 1'b0;
    end else begin
      res_o     <= nxt_res;
      illegal_o <= rsv_code;
    end
  end

  p_rsv_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_sz == 2'd3) |=> (illegal_o && (res_o == '0)));

  p_legal_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_sz != 2'd3) |=> !illegal_o);

  p_narrow_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_sel |=> (res_o[VEC_W-1:HALF] == '0));

  p_reset_clear_r7: assert property (@(posedge clk)
    !rst_n |=> ((res_o == '0) && !illegal_o));

endmodule

// File: tb/test_halving_simd_unit.sv
module test_halving_simd_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] opa_i = '0;
  logic [127:0] opb_i = '0;
  logic         sub_sel = 1'b0;
  logic         uns_sel = 1'b0;
  logic [1:0]   lane_sz = 2'd0;
  logic         wide_sel = 1'b1;
  logic [127:0] res_o;
  logic         illegal_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  halving_simd_unit i_halving_simd_unit (
    .clk, .rst_n, .opa_i, .opb_i, .sub_sel, .uns_sel,
    .lane_sz, .wide_sel, .res_o, .illegal_o
  );

  // Reference on wide integers; floor halving done by division.
  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic sub, input logic uns,
                                         input logic [1:0] sz, input logic wide);
    logic [127:0] r;
    int lw;
    int n;
    longint m;
    r = '0;
    if (sz == 2'd3) return r;
    lw = 8 << sz;
    n  = (wide ? 128 : 64) / lw;
    m  = (longint'(1) << lw) - 1;
    for (int k = 0; k < n; k++) begin
      longint ea, eb, d, q;
      ea = longint'((a >> (k * lw)) & 128'(m));
      eb = longint'((b >> (k * lw)) & 128'(m));
      if (!uns && ((ea >> (lw - 1)) & 1) == 1) ea = ea - (longint'(1) << lw);
      if (!uns && ((eb >> (lw - 1)) & 1) == 1) eb = eb - (longint'(1) << lw);
      d = sub ? (ea - eb) : (ea + eb);
      q = d / 2;
      if (d < 0 && (d % 2) != 0) q = q - 1;
      r = r | (128'(q & m) << (k * lw));
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic apply(input logic [127:0] a, input logic [127:0] b, input logic sub,
                       input logic uns, input logic [1:0] sz, input logic wide,
                       input string tag);
    logic [127:0] exp_res;
    logic         exp_ill;
    @(negedge clk);
    opa_i = a; opb_i = b; sub_sel = sub; uns_sel = uns; lane_sz = sz; wide_sel = wide;
    exp_res = model(a, b, sub, uns, sz, wide);
    exp_ill = (sz == 2'd3);
    @(negedge clk);
    n_vec++;
    if (res_o !== exp_res || illegal_o !== exp_ill) begin
      n_fail++;
      $display("FAIL %s: res=%h ill=%b expected res=%h ill=%b", tag, res_o, illegal_o,
               exp_res, exp_ill);
    end
  endtask

  task automatic t_reset();  // R7
    rst_n = 1'b0;
    opa_i = '1; opb_i = '1; lane_sz = 2'd3;
    repeat (3) @(negedge clk);
    n_vec++;
    if (res_o !== '0 || illegal_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R7 reset: res=%h ill=%b expected res=0 ill=0", res_o, illegal_o);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_add_basic();  // R1
    apply({16{8'd10}}, {16{8'd5}}, 1'b0, 1'b1, 2'd0, 1'b1, "R1 u8 add");
    apply({8{16'd301}}, {8{16'd4}}, 1'b0, 1'b0, 2'd1, 1'b1, "R1 s16 add odd");
    apply({4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, 1'b0, 1'b1, 2'd2, 1'b1, "R1 u32 add carry");
  endtask

  task automatic t_sub_basic();  // R2
    apply({16{8'd9}}, {16{8'd2}}, 1'b1, 1'b1, 2'd0, 1'b1, "R2 u8 sub");
    apply({8{16'hFFFD}}, {8{16'd0}}, 1'b1, 1'b0, 2'd1, 1'b1, "R2 s16 sub neg odd");
    apply({4{32'h8000_0000}}, {4{32'h7FFF_FFFF}}, 1'b1, 1'b0, 2'd2, 1'b1, "R2 s32 min-max");
  endtask

  task automatic t_type_edges();  // R3
    apply({16{8'h80}}, {16{8'h80}}, 1'b0, 1'b0, 2'd0, 1'b1, "R3 s8 min+min");
    apply({16{8'h7F}}, {16{8'h7F}}, 1'b0, 1'b0, 2'd0, 1'b1, "R3 s8 max+max");
    apply({16{8'hFF}}, {16{8'hFF}}, 1'b0, 1'b1, 2'd0, 1'b1, "R3 u8 max+max");
    apply({16{8'hFF}}, {16{8'h01}}, 1'b0, 1'b0, 2'd0, 1'b1, "R3 s8 -1+1");
    apply({8{16'h7FFF}}, {8{16'h8000}}, 1'b1, 1'b0, 2'd1, 1'b1, "R3 s16 max-min");
  endtask

  task automatic t_lane_sizes();  // R4
    for (int s = 0; s < 3; s++) begin
      apply('1, '1, 1'b0, 1'b1, 2'(s), 1'b1, "R4 all-ones add");
      apply('0, '1, 1'b1, 1'b1, 2'(s), 1'b1, "R4 zero-minus-ones borrow");
      apply({64{2'b01}}, {64{2'b11}}, 1'b0, 1'b0, 2'(s), 1'b1, "R4 mixed pattern");
    end
  endtask

  task automatic t_unsigned_neg();  // R8
    apply({16{8'h00}}, {16{8'h01}}, 1'b1, 1'b1, 2'd0, 1'b1, "R8 u8 0-1");
    apply({8{16'h0000}}, {8{16'hFFFF}}, 1'b1, 1'b1, 2'd1, 1'b1, "R8 u16 0-max");
    apply({4{32'h0000_0003}}, {4{32'hFFFF_FFF0}}, 1'b1, 1'b1, 2'd2, 1'b1, "R8 u32 small-big");
  endtask

  task automatic t_narrow();  // R5
    for (int s = 0; s < 3; s++) begin
      logic [127:0] a, b;
      a = rnd128(); b = rnd128();
      apply(a, b, 1'b0, 1'b0, 2'(s), 1'b0, "R5 narrow add");
      apply({rnd128() & {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}} | {64'h0, a[63:0]},
            b, 1'b0, 1'b0, 2'(s), 1'b0, "R5 upper operand ignored");
      apply(a, b, 1'b1, 1'b1, 2'(s), 1'b1, "R5 wide sub");
    end
  endtask

  task automatic t_reserved();  // R6
    apply('1, '1, 1'b0, 1'b1, 2'd3, 1'b1, "R6 reserved wide");
    apply(rnd128(), rnd128(), 1'b1, 1'b0, 2'd3, 1'b0, "R6 reserved narrow");
    apply({16{8'h42}}, {16{8'h02}}, 1'b0, 1'b1, 2'd0, 1'b1, "R6 legal after reserved");
  endtask

  task automatic t_random();  // R1 R2 R3 R4 R7
    for (int it = 0; it < 40; it++) begin
      for (int c = 0; c < 12; c++) begin
        apply(rnd128(), rnd128(), 1'(c & 1), 1'((c >> 1) & 1), 2'(c >> 2),
              1'($urandom & 1), "R1/R2 random sweep");
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add_basic();
    t_sub_basic();
    t_type_edges();
    t_lane_sizes();
    t_unsigned_neg();
    t_narrow();
    t_reserved();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule